// File: doc/BRIEF.md
# Paged Interrupt Priority Router

This block decides which of 128 maskable interrupt requests is presented to the main CPU and which to a secondary coprocessor. Each request has its own configuration byte. Bit 7 of the byte selects the target and bits 2:0 set a priority level from 0 to 7, where level 0 switches the request off. Requests are identified by an even vector offset: request line `n` has offset `2*n`.

Software cannot see all 128 bytes at once. It writes a page address into a window register, and that page maps sixteen bytes of offset space, which is eight vectors, onto eight data registers. Separately for each target, the block picks the pending request with the highest level. It presents that request only if it may preempt the level currently in service. It tracks the level in service itself. An accept input enters the new level and saves the old one. A service-complete input restores the saved level.

A non-maskable request outranks every maskable request on the CPU side and never reaches the coprocessor.

Top module: `irq_page_router`

## Requirements
- R1: After reset, every configuration byte reads 0x01 (CPU target, level 1). The window register reads 0x00, both levels in service are 0, and neither request output is raised.
- R2: Writing register address 0 loads the window register with the written value, low nibble forced to zero. Reading address 0 returns that value.
- R3: Register address 8+i (i = 0..7) reads and writes the configuration byte of vector offset `window + 2*i`. A write is visible from the next cycle. Addresses 1 to 7 read 0 and ignore writes.
- R4: A write through the window changes only the one addressed byte, and bytes in every other page keep their values.
- R5: Configuration bit 7 equal to 1 sends the request to the coprocessor path, and 0 keeps it on the CPU path.
- R6: A request whose level field (bits 2:0) is 0 never takes part in arbitration.
- R7: On each path the winner is the active, enabled request of that target with the highest level. On equal levels the higher vector offset wins. The vector output carries the winner's offset, and 0 when there is no winner.
- R8: `cpu_irq` is high exactly when the CPU mask is clear, no non-maskable request is pending, and the CPU winner's level is strictly above the CPU level in service.
- R9: `cpu_ack` while `cpu_irq` is high makes the winner's level the new CPU level in service and saves the previous one. A request at the same level as the one in service does not raise `cpu_irq`.
- R10: `cpu_done` restores the most recently saved CPU level, or 0 when nothing is saved. `cpu_done` takes precedence over an accept in the same cycle. Up to 7 levels can be saved.
- R11: The coprocessor path ranks levels in two tiers: 1 to 3 is the low tier and 4 to 7 the high tier. `cop_irq` is high only when the winner's tier is above the tier in service. `cop_ack` and `cop_done` enter and restore levels as on the CPU path.
- R12: `cpu_nmi` follows `nmi_req`. While `nmi_req` is high, `cpu_irq` stays low, and the coprocessor path is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0 window, 8..15 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_req | input | 128 | Maskable request lines, line n at offset 2n |
| nmi_req | input | 1 | Non-maskable request |
| cpu_mask | input | 1 | CPU global mask bit |
| cpu_ack | input | 1 | CPU accepts the presented request |
| cpu_done | input | 1 | CPU finished the request in service |
| cop_ack | input | 1 | Coprocessor accepts the presented request |
| cop_done | input | 1 | Coprocessor finished the request in service |
| cpu_irq | output | 1 | Maskable request to the CPU |
| cpu_nmi | output | 1 | Non-maskable request to the CPU |
| cpu_vec | output | 8 | CPU winner vector offset |
| cpu_level | output | 3 | CPU level in service |
| cop_irq | output | 1 | Request to the coprocessor |
| cop_vec | output | 8 | Coprocessor winner vector offset |
| cop_level | output | 3 | Coprocessor level in service |

## Verification
The assertions assume that the accept inputs arrive only while the matching request output is high, or else have no effect. They also assume that levels are only saved on a strict rise, so a restore never yields a higher CPU level. They also take reset to be held at the start of the run, before any `$past` comparison matters.

The stimulus draws register traffic, sparse request patterns, the mask, rare non-maskable pulses and random accept and complete strobes from a seeded generator. A bench model mirrors the configuration bytes, the window and both level stacks. Directed sequences first cover the reset values, the window masking, the isolation between pages, a disabled level, a tie on level and both preemption rules.

// File: rtl/irq_page_pkg.sv
// Package: shared constants, types and the nesting-rank helper for the
// paged interrupt priority router. Assumes 8-bit configuration bytes.
package irq_page_pkg;
    localparam int CFG_W      = 8;
    localparam int LVL_W      = 3;
    localparam int ROUTE_BIT  = 7;
    localparam logic [CFG_W-1:0] CFG_RESET = 8'h01;
    localparam int TIER_SPLIT = 4;

    typedef logic [LVL_W-1:0] level_t;

    typedef enum logic {
        TGT_CPU = 1'b0,
        TGT_COP = 1'b1
    } target_e;

    // Rank used for preemption: plain level, or two tiers when tiered.
    function automatic level_t nest_rank(level_t lvl, logic tiered);
        if (!tiered)              return lvl;
        else if (lvl == '0)       return level_t'(0);
        else if (lvl < level_t'(TIER_SPLIT)) return level_t'(1);
        else                      return level_t'(2);
    endfunction
endpackage

// File: rtl/irq_cfg_window.sv
// Module: configuration byte store with a paged eight-entry window.
// Address 0 is the window register (page number, low bits read as 0);
// addresses with the top address bit set select one byte of the page.
// Assumes NUM_VEC and WIN_SIZE are powers of two and offsets fit CFG_W.
module irq_cfg_window
    import irq_page_pkg::*;
#(
    parameter int NUM_VEC  = 128,
    parameter int WIN_SIZE = 8,
    localparam int VEC_W   = $clog2(NUM_VEC),
    localparam int IDX_W   = $clog2(WIN_SIZE),
    localparam int PAGE_W  = VEC_W - IDX_W,
    localparam int OFS_W   = VEC_W + 1,
    localparam int ADDR_W  = IDX_W + 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [CFG_W-1:0]              wdata,
    output logic [CFG_W-1:0]              rdata,
    output logic [NUM_VEC-1:0]            route_o,
    output logic [NUM_VEC-1:0][LVL_W-1:0] lvl_o
);
    logic [PAGE_W-1:0] page_q;
    logic [CFG_W-1:0]  cfg_q [NUM_VEC];
    logic              win_hit;
    logic              data_hit;
    logic [VEC_W-1:0]  sel_vec;

    assign win_hit  = (addr == '0);
    assign data_hit = addr[IDX_W];
    assign sel_vec  = {page_q, addr[IDX_W-1:0]};

    // Window register: keeps only the page part of the written offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (we && win_hit)
            page_q <= wdata[OFS_W-1 -: PAGE_W];
    end

    // One configuration byte per vector, written only when selected.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q[v] <= CFG_RESET;
            else if (we && data_hit && sel_vec == VEC_W'(v))
                cfg_q[v] <= wdata;
        end
        assign route_o[v] = cfg_q[v][ROUTE_BIT];
        assign lvl_o[v]   = cfg_q[v][LVL_W-1:0];
    end

    // Read mux: window value, the selected byte, or zero.
    always_comb begin
        if (win_hit)
            rdata = CFG_W'({page_q, {(IDX_W + 1){1'b0}}});
        else if (data_hit)
            rdata = cfg_q[sel_vec];
        else
            rdata = '0;
    end
endmodule

// File: rtl/irq_target_arb.sv
// Module: picks the highest-level active request routed to one target.
// Ties go to the higher vector. Level 0 entries never win.
// Output offset is the vector index times two; 0 when nothing wins.
module irq_target_arb
    import irq_page_pkg::*;
#(
    parameter int      NUM_VEC = 128,
    parameter target_e TARGET  = TGT_CPU,
    localparam int VEC_W = $clog2(NUM_VEC),
    localparam int OFS_W = VEC_W + 1
) (
    input  logic [NUM_VEC-1:0]            req,
    input  logic [NUM_VEC-1:0]            route,
    input  logic [NUM_VEC-1:0][LVL_W-1:0] lvl,
    output level_t                        win_lvl,
    output logic [OFS_W-1:0]              win_vec
);
    logic [VEC_W-1:0] best_idx;
    level_t           best_lvl;

    // Linear scan upward; >= lets a later vector take over a tie.
    always_comb begin
        best_idx = '0;
        best_lvl = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (req[v] && (route[v] == TARGET) && (lvl[v] != '0)
                && (lvl[v] >= best_lvl)) begin
                best_lvl = lvl[v];
                best_idx = VEC_W'(v);
            end
        end
        win_lvl = best_lvl;
        win_vec = {best_idx, 1'b0};
    end
endmodule

// File: rtl/irq_nest_track.sv
// Module: level in service for one target with a save stack.
// Decides whether the winner may preempt (by plain level or by tier).
// Assumes take only while preemption is allowed; done outranks take.
module irq_nest_track
    import irq_page_pkg::*;
#(
    parameter int   DEPTH  = 7,
    parameter logic TIERED = 1'b0,
    localparam int  SP_W   = $clog2(DEPTH + 1)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  level_t win_lvl,
    input  logic   take,
    input  logic   done,
    output level_t cur_lvl,
    output logic   can_preempt
);
    level_t          stk [DEPTH];
    logic [SP_W-1:0] sp_q;
    level_t          cur_q;
    logic            push_ok;

    assign push_ok     = take && !done && (sp_q < SP_W'(DEPTH));
    assign can_preempt = nest_rank(win_lvl, TIERED) > nest_rank(cur_q, TIERED);
    assign cur_lvl     = cur_q;

    // Level in service and stack pointer: restore on done, enter on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            sp_q  <= '0;
        end else if (done) begin
            if (sp_q != '0) begin
                cur_q <= stk[sp_q - SP_W'(1)];
                sp_q  <= sp_q - SP_W'(1);
            end else begin
                cur_q <= '0;
            end
        end else if (take) begin
            cur_q <= win_lvl;
            if (push_ok)
                sp_q <= sp_q + SP_W'(1);
        end
    end

    // Stack storage: saves the outgoing level on an accepted request.
    always_ff @(posedge clk) begin
        if (push_ok)
            stk[sp_q] <= cur_q;
    end
endmodule

// File: rtl/irq_page_router.sv
// Module: top of the paged interrupt priority router. Joins the windowed
// configuration store, one arbiter per target and one nesting tracker per
// target. Non-maskable requests pass straight to the CPU and hold off
// maskable CPU requests. Assumes accepts are only given while presented.
module irq_page_router
    import irq_page_pkg::*;
#(
    parameter int NUM_VEC     = 128,
    parameter int WIN_SIZE    = 8,
    parameter int STACK_DEPTH = 7,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int OFS_W  = VEC_W + 1,
    localparam int ADDR_W = $clog2(WIN_SIZE) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [CFG_W-1:0]   reg_wdata,
    output logic [CFG_W-1:0]   reg_rdata,
    input  logic [NUM_VEC-1:0] irq_req,
    input  logic               nmi_req,
    input  logic               cpu_mask,
    input  logic               cpu_ack,
    input  logic               cpu_done,
    input  logic               cop_ack,
    input  logic               cop_done,
    output logic               cpu_irq,
    output logic               cpu_nmi,
    output logic [OFS_W-1:0]   cpu_vec,
    output logic [LVL_W-1:0]   cpu_level,
    output logic               cop_irq,
    output logic [OFS_W-1:0]   cop_vec,
    output logic [LVL_W-1:0]   cop_level
);
    logic [NUM_VEC-1:0]            route;
    logic [NUM_VEC-1:0][LVL_W-1:0] lvl;
    level_t                        cpu_win_lvl;
    level_t                        cop_win_lvl;
    logic                          cpu_pre;
    logic                          cop_pre;

    irq_cfg_window #(.NUM_VEC(NUM_VEC), .WIN_SIZE(WIN_SIZE)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .route_o (route),
        .lvl_o   (lvl)
    );

    irq_target_arb #(.NUM_VEC(NUM_VEC), .TARGET(TGT_CPU)) u_arb_cpu (
        .req     (irq_req),
        .route   (route),
        .lvl     (lvl),
        .win_lvl (cpu_win_lvl),
        .win_vec (cpu_vec)
    );

    irq_target_arb #(.NUM_VEC(NUM_VEC), .TARGET(TGT_COP)) u_arb_cop (
        .req     (irq_req),
        .route   (route),
        .lvl     (lvl),
        .win_lvl (cop_win_lvl),
        .win_vec (cop_vec)
    );

    irq_nest_track #(.DEPTH(STACK_DEPTH), .TIERED(1'b0)) u_trk_cpu (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_lvl     (cpu_win_lvl),
        .take        (cpu_ack && cpu_irq),
        .done        (cpu_done),
        .cur_lvl     (cpu_level),
        .can_preempt (cpu_pre)
    );

    irq_nest_track #(.DEPTH(STACK_DEPTH), .TIERED(1'b1)) u_trk_cop (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_lvl     (cop_win_lvl),
        .take        (cop_ack && cop_irq),
        .done        (cop_done),
        .cur_lvl     (cop_level),
        .can_preempt (cop_pre)
    );

    // Request outputs: non-maskable path outranks the masked CPU path.
    assign cpu_nmi = nmi_req;
    assign cpu_irq = !nmi_req && !cpu_mask && cpu_pre;
    assign cop_irq = cop_pre;
endmodule

// File: rtl/irq_page_router_chk.sv
// Module: property checker for irq_page_router, attached by bind.
// Assumes reset is asserted before the first checked cycle.
module irq_page_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [3:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       nmi_req,
    input logic       cpu_mask,
    input logic       cpu_ack,
    input logic       cpu_done,
    input logic       cpu_irq,
    input logic       cpu_nmi,
    input logic [2:0] cpu_level,
    input logic [2:0] cpu_win_lvl,
    input logic       cop_irq,
    input logic [2:0] cop_level,
    input logic [2:0] cop_win_lvl
);
    // R2: window read-back never shows low offset bits
    assert_window_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'd0) |-> (reg_rdata[3:0] == 4'd0));

    // R3: a data write reads back the next cycle at the same address
    assert_data_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr[3]) |=> ((reg_addr != $past(reg_addr)) || (reg_rdata == $past(reg_wdata))));

    // R8: CPU request only when unmasked and strictly above level in service
    assert_cpu_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (!cpu_mask && (cpu_win_lvl > cpu_level)));

    // R9: an accepted CPU request raises the level in service
    assert_cpu_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && cpu_irq && !cpu_done) |=> (cpu_level > $past(cpu_level)));

    // R10: service complete lowers the CPU level or leaves it at zero
    assert_cpu_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> ((cpu_level < $past(cpu_level)) || (cpu_level == 3'd0)));

    // R11: coprocessor low tier only preempted by the high tier
    assert_cop_tier_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cop_irq |-> ((cop_level == 3'd0) || ((cop_level < 3'd4) && (cop_win_lvl >= 3'd4))));

    // R12: non-maskable request is passed on and blocks the maskable CPU path
    assert_nmi_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (cpu_nmi && !cpu_irq));
endmodule

bind irq_page_router irq_page_router_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .nmi_req     (nmi_req),
    .cpu_mask    (cpu_mask),
    .cpu_ack     (cpu_ack),
    .cpu_done    (cpu_done),
    .cpu_irq     (cpu_irq),
    .cpu_nmi     (cpu_nmi),
    .cpu_level   (cpu_level),
    .cpu_win_lvl (cpu_win_lvl),
    .cop_irq     (cop_irq),
    .cop_level   (cop_level),
    .cop_win_lvl (cop_win_lvl)
);

// File: tb/irq_page_router_tb.sv
// Bench: directed corner cases then seeded random traffic, all outputs
// compared each cycle against a bench model of bytes, window and stacks.
module irq_page_router_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         reg_we;
    logic [3:0]   reg_addr;
    logic [7:0]   reg_wdata;
    logic [7:0]   reg_rdata;
    logic [127:0] irq_req;
    logic         nmi_req, cpu_mask, cpu_ack, cpu_done, cop_ack, cop_done;
    logic         cpu_irq, cpu_nmi, cop_irq;
    logic [7:0]   cpu_vec, cop_vec;
    logic [2:0]   cpu_level, cop_level;

    int total = 0;
    int bad   = 0;
    bit over  = 0;

    logic [7:0] cfg_m [128];
    int page_m;
    int cur_m [2];
    int sp_m  [2];
    int stk_m [2][8];

    always #5 clk = ~clk;

    irq_page_router u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
        .nmi_req(nmi_req), .cpu_mask(cpu_mask), .cpu_ack(cpu_ack),
        .cpu_done(cpu_done), .cop_ack(cop_ack), .cop_done(cop_done),
        .cpu_irq(cpu_irq), .cpu_nmi(cpu_nmi), .cpu_vec(cpu_vec),
        .cpu_level(cpu_level), .cop_irq(cop_irq), .cop_vec(cop_vec),
        .cop_level(cop_level)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int rank(input int t, input int l);
        if (t == 0) return l;
        if (l == 0) return 0;
        return (l < 4) ? 1 : 2;
    endfunction

    function automatic void arb(input int t, output int wl, output int wv);
        wl = 0;
        wv = 0;
        for (int v = 0; v < 128; v++) begin
            if (irq_req[v] && int'(cfg_m[v][7]) == t && cfg_m[v][2:0] != 3'd0
                && int'(cfg_m[v][2:0]) >= wl) begin
                wl = int'(cfg_m[v][2:0]);
                wv = 2 * v;
            end
        end
    endfunction

    function automatic int exp_rdata();
        if (reg_addr == 4'd0) return page_m * 16;
        if (reg_addr[3])      return int'(cfg_m[page_m * 8 + int'(reg_addr[2:0])]);
        return 0;
    endfunction

    task automatic trk(input int t, input bit take, input bit done, input int wl);
        if (done) begin
            if (sp_m[t] > 0) begin
                sp_m[t]--;
                cur_m[t] = stk_m[t][sp_m[t]];
            end else cur_m[t] = 0;
        end else if (take) begin
            if (sp_m[t] < 7) begin
                stk_m[t][sp_m[t]] = cur_m[t];
                sp_m[t]++;
            end
            cur_m[t] = wl;
        end
    endtask

    // One cycle: compare every output to the model, advance model, clock.
    task automatic step();
        int l0, v0, l1, v1;
        bit e0, e1;
        #1;
        arb(0, l0, v0);
        arb(1, l1, v1);
        e0 = !nmi_req && !cpu_mask && (l0 > cur_m[0]);
        e1 = rank(1, l1) > rank(1, cur_m[1]);
        chk(cpu_vec == 8'(v0), "R7 cpu_vec", cpu_vec, v0);
        chk(cop_vec == 8'(v1), "R7 cop_vec", cop_vec, v1);
        chk(cpu_irq == e0, "R8 cpu_irq", cpu_irq, e0);
        chk(cop_irq == e1, "R11 cop_irq", cop_irq, e1);
        chk(cpu_nmi == nmi_req, "R12 cpu_nmi", cpu_nmi, nmi_req);
        chk(int'(cpu_level) == cur_m[0], "R9 R10 cpu_level", cpu_level, cur_m[0]);
        chk(int'(cop_level) == cur_m[1], "R11 cop_level", cop_level, cur_m[1]);
        chk(int'(reg_rdata) == exp_rdata(), "R3 rdata", reg_rdata, exp_rdata());
        trk(0, cpu_ack && e0, cpu_done, l0);
        trk(1, cop_ack && e1, cop_done, l1);
        if (reg_we) begin
            if (reg_addr == 4'd0) page_m = int'(reg_wdata[7:4]);
            else if (reg_addr[3]) cfg_m[page_m * 8 + int'(reg_addr[2:0])] = reg_wdata;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        reg_we    = 1'b1;
        reg_addr  = 4'(a);
        reg_wdata = 8'(d);
        step();
        reg_we    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!over) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        irq_req = '0; nmi_req = 1'b0; cpu_mask = 1'b0;
        cpu_ack = 1'b0; cpu_done = 1'b0; cop_ack = 1'b0; cop_done = 1'b0;
        for (int v = 0; v < 128; v++) cfg_m[v] = 8'h01;
        page_m = 0;
        for (int t = 0; t < 2; t++) begin cur_m[t] = 0; sp_m[t] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(reg_rdata == 8'h00, "R1 window", reg_rdata, 0);
        for (int i = 0; i < 8; i++) begin
            reg_addr = 4'(8 + i);
            #1 chk(reg_rdata == 8'h01, "R1 cfg byte", reg_rdata, 1);
        end
        chk(!cpu_irq && !cop_irq, "R1 irq low", {cpu_irq, cop_irq}, 0);
        chk(cpu_level == 0 && cop_level == 0, "R1 levels", {cpu_level, cop_level}, 0);
        step();
        // R2: window masking
        wr(0, 8'h37);
        reg_addr = 4'd0;
        #1 chk(reg_rdata == 8'h30, "R2 window mask", reg_rdata, 8'h30);
        // R4: page isolation
        wr(10, 8'h85);
        wr(0, 8'h50);
        wr(10, 8'h06);
        wr(0, 8'h30);
        reg_addr = 4'd10;
        #1 chk(reg_rdata == 8'h85, "R4 other page kept", reg_rdata, 8'h85);
        // R5: route to coprocessor, vector 26 at offset 0x34
        irq_req[26] = 1'b1;
        #1 chk(cop_irq && cop_vec == 8'h34, "R5 cop route", cop_vec, 8'h34);
        chk(!cpu_irq, "R5 not on cpu", cpu_irq, 0);
        step();
        // R6: level 0 disables
        wr(10, 8'h80);
        #1 chk(!cop_irq, "R6 level zero", cop_irq, 0);
        // R7 tie: vectors 25 and 28 at CPU level 5
        wr(9, 8'h05);
        wr(12, 8'h05);
        irq_req[25] = 1'b1;
        irq_req[28] = 1'b1;
        #1 chk(cpu_vec == 8'h38 && cpu_irq, "R7 tie higher vector", cpu_vec, 8'h38);
        cpu_ack = 1'b1;
        step();
        cpu_ack = 1'b0;
        #1 chk(cpu_level == 3'd5 && !cpu_irq, "R9 same level no nest", cpu_level, 5);
        // R12: NMI blocks a higher CPU request
        wr(13, 8'h07);
        irq_req[29] = 1'b1;
        nmi_req = 1'b1;
        #1 chk(!cpu_irq && cpu_nmi, "R12 nmi blocks", cpu_irq, 0);
        nmi_req = 1'b0;
        #1 chk(cpu_irq, "R8 higher level preempts", cpu_irq, 1);
        cpu_done = 1'b1;
        step();
        cpu_done = 1'b0;
        #1 chk(cpu_level == 3'd0, "R10 restore empty", cpu_level, 0);
        // R11: coprocessor tiers
        wr(10, 8'h82);
        cop_ack = 1'b1;
        step();
        cop_ack = 1'b0;
        #1 chk(cop_level == 3'd2, "R11 cop entered", cop_level, 2);
        wr(9, 8'h83);
        #1 chk(!cop_irq, "R11 low tier no nest", cop_irq, 0);
        wr(12, 8'h84);
        #1 chk(cop_irq && cop_vec == 8'h38, "R11 high tier nests", cop_irq, 1);
        cop_done = 1'b1;
        step();
        cop_done = 1'b0;
        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            for (int v = 0; v < 128; v++) irq_req[v] = ($urandom % 16) == 0;
            reg_we    = ($urandom % 10) < 3;
            reg_addr  = ($urandom % 3 == 0) ? 4'd0 : 4'($urandom % 16);
            reg_wdata = 8'($urandom);
            cpu_mask  = ($urandom % 10) == 0;
            nmi_req   = ($urandom % 32) == 0;
            cpu_ack   = ($urandom % 10) < 4;
            cpu_done  = ($urandom % 8) == 0;
            cop_ack   = ($urandom % 10) < 4;
            cop_done  = ($urandom % 8) == 0;
            step();
        end
        over = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule